// File: doc/BRIEF.md
# Oversampled Serial Framer

This block is the bit engine of an asynchronous serial port. A 16-bit divisor sets a tick rate of one tick every divisor+1 clocks. Sixteen ticks make one bit time, so the bit rate is the clock divided by 16*(divisor+1). Four plain configuration pins choose the character format: 7 or 8 data bits, one or two stop bits, and an optional parity bit that is even or odd. The transmit side and the receive side share these pins. Each side reads them when its frame begins.

The transmitter takes bytes from a valid/ready source and shifts them out on `txd`. A byte is taken only in a cycle where `tx_valid` and `tx_ready` are both high. The receiver watches `rxd` and rebuilds each character. It offers the character on a valid/ready output. The character comes with three error flags and a 2-bit error code that ranks them. Once `rx_valid` is raised, `rx_data`, the flags and the code hold steady until the cycle in which `rx_ready` is high. The line is high when idle. The `tx_en` and `rx_en` inputs turn each direction on or off.

Top module: `serial_framer`

## Requirements
- R1: Each transmitted bit lasts exactly 16*(divisor+1) clocks. The start bit begins on the clock edge that accepts the byte.
- R2: A transmitted frame is a low start bit followed by the data bits, least significant first. There are 8 data bits when `cfg_len8`=1 and 7 data bits (bits 6..0) when it is 0.
- R3: When `cfg_par_en`=1, a parity bit follows the data bits. With `cfg_par_odd`=0 it makes the count of ones in the data and parity bits even. With `cfg_par_odd`=1 it makes that count odd.
- R4: The frame ends with one high stop bit, or two when `cfg_two_stop`=1.
- R5: `tx_ready` is high only while no frame is in progress. `txd` goes low on the edge that accepts a byte. The format pins are read on that edge, so changing them during the frame has no effect on it.
- R6: `tx_idle` is high only when no frame is in progress and `tx_valid` is low. It rises on the clock edge that ends the last stop bit. `txd` is high whenever `tx_idle` is high.
- R7: `rxd` passes through two synchroniser stages and an edge register. A falling edge therefore starts a frame 3 clocks after the line falls. The start bit is checked again at tick 8. If the line is high there, the start is dropped and no character is produced. Every later bit is sampled 16 ticks after the previous sample. A 7-bit character is delivered with bit 7 equal to 0.
- R8: `rx_par_err` is set when parity is enabled and the received parity bit does not match the parity rule in R3.
- R9: `rx_frm_err` is set when the first stop bit is sampled low. A second stop bit is not checked.
- R10: A character is delivered in the clock edge where its first stop bit is sampled. It is delivered if the output is empty, or if the held character is taken in that same cycle. Otherwise the new character is discarded, the held character stays unchanged, and the next character delivered has `rx_ovr_err`=1.
- R11: `rx_err_code` ranks the flags of the delivered character. It is 1 for a parity error, else 2 for a frame error, else 3 for an overrun, else 0.
- R12: While `tx_en` is low, `tx_ready` stays low and `txd` stays high. While `rx_en` is low, no new character is delivered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| divisor | input | 16 | Tick divider; one tick every divisor+1 clocks |
| cfg_len8 | input | 1 | 1: 8 data bits, 0: 7 data bits |
| cfg_two_stop | input | 1 | 1: two stop bits, 0: one stop bit |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_odd | input | 1 | 1: odd parity, 0: even parity |
| tx_en | input | 1 | Transmit direction enable |
| tx_data | input | 8 | Byte to send |
| tx_valid | input | 1 | `tx_data` is offered |
| tx_ready | output | 1 | Transmitter can take a byte |
| txd | output | 1 | Serial output line |
| tx_idle | output | 1 | Transmitter quiet and nothing pending |
| rx_en | input | 1 | Receive direction enable |
| rxd | input | 1 | Serial input line |
| rx_data | output | 8 | Received character |
| rx_par_err | output | 1 | Parity error on this character |
| rx_frm_err | output | 1 | Frame error on this character |
| rx_ovr_err | output | 1 | A character was lost before this one |
| rx_err_code | output | 2 | Ranked error code (see R11) |
| rx_valid | output | 1 | Received character offered |
| rx_ready | input | 1 | Consumer takes the character |

## Verification
Two events can fall in the same clock edge: the receiver finishing a character and the consumer taking the character already held. The bench holds one character unread. It then sends a second one and raises `rx_ready` for exactly the edge in which the second first stop bit is sampled. That edge is worked out from the 3-clock start latency and the tick-8 sample point. In that case the second character must appear with no overrun flag. In a second run the pulse comes one edge late. There the second character must be lost, and the next character must carry the overrun flag with code 3.

// File: rtl/sfr_pkg.sv
package sfr_pkg;

  localparam int unsigned SFR_DW = 8;

  typedef struct packed {
    logic len8;
    logic two_stop;
    logic par_en;
    logic par_odd;
  } sfr_fmt_t;

  typedef enum logic [1:0] {
    ERR_NONE    = 2'd0,
    ERR_PARITY  = 2'd1,
    ERR_FRAME   = 2'd2,
    ERR_OVERRUN = 2'd3
  } sfr_err_t;

  // Parity bit value that satisfies the chosen rule over the active data bits.
  function automatic logic sfr_parity(input logic [SFR_DW-1:0] d,
                                      input logic len8,
                                      input logic odd);
    return (^{d[SFR_DW-1] & len8, d[SFR_DW-2:0]}) ^ odd;
  endfunction

endpackage

// File: rtl/sfr_tick_gen.sv
module sfr_tick_gen #(
  parameter int unsigned DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);

  logic [DIV_W-1:0] cnt_q;

  assign tick = !clr && (cnt_q >= div);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (clr || (cnt_q >= div)) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/sfr_tx.sv
module sfr_tx
  import sfr_pkg::*;
#(
  parameter int unsigned DIV_W = 16,
  parameter int unsigned OSR   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DIV_W-1:0]  div,
  input  sfr_fmt_t          fmt,
  input  logic              en,
  input  logic [SFR_DW-1:0] data,
  input  logic              valid,
  output logic              ready,
  output logic              line,
  output logic              idle
);

  localparam int unsigned SUB_W = $clog2(OSR);
  localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(OSR - 1);

  typedef enum logic [2:0] {T_IDLE, T_START, T_DATA, T_PAR, T_STOP} tx_st_t;

  tx_st_t            st_q;
  logic [SUB_W-1:0]  sub_q;
  logic [2:0]        bitn_q;
  logic [SFR_DW-1:0] sh_q;
  logic              par_q;
  sfr_fmt_t          fmt_q;
  logic              line_q;
  logic              tick;
  logic              accept;
  logic [2:0]        last_data;

  assign ready     = en && (st_q == T_IDLE);
  assign accept    = valid && ready;
  assign idle      = (st_q == T_IDLE) && !valid;
  assign line      = line_q;
  assign last_data = fmt_q.len8 ? 3'd7 : 3'd6;

  sfr_tick_gen #(.DIV_W(DIV_W)) u_tick (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (accept),
    .div  (div),
    .tick (tick)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= T_IDLE;
      sub_q  <= '0;
      bitn_q <= '0;
      sh_q   <= '0;
      par_q  <= 1'b0;
      fmt_q  <= '0;
      line_q <= 1'b1;
    end else if (accept) begin
      st_q   <= T_START;
      sub_q  <= '0;
      bitn_q <= '0;
      sh_q   <= data;
      par_q  <= sfr_parity(data, fmt.len8, fmt.par_odd);
      fmt_q  <= fmt;
      line_q <= 1'b0;
    end else if ((st_q != T_IDLE) && tick) begin
      sub_q <= (sub_q == SUB_LAST) ? '0 : sub_q + 1'b1;
      if (sub_q == SUB_LAST) begin
        case (st_q)
          T_START: begin
            st_q   <= T_DATA;
            bitn_q <= '0;
            line_q <= sh_q[0];
            sh_q   <= sh_q >> 1;
          end
          T_DATA: begin
            if (bitn_q == last_data) begin
              bitn_q <= '0;
              if (fmt_q.par_en) begin
                st_q   <= T_PAR;
                line_q <= par_q;
              end else begin
                st_q   <= T_STOP;
                line_q <= 1'b1;
              end
            end else begin
              bitn_q <= bitn_q + 1'b1;
              line_q <= sh_q[0];
              sh_q   <= sh_q >> 1;
            end
          end
          T_PAR: begin
            st_q   <= T_STOP;
            bitn_q <= '0;
            line_q <= 1'b1;
          end
          T_STOP: begin
            line_q <= 1'b1;
            if (fmt_q.two_stop && (bitn_q == 3'd0)) begin
              bitn_q <= 3'd1;
            end else begin
              st_q <= T_IDLE;
            end
          end
          default: st_q <= T_IDLE;
        endcase
      end
    end
  end

endmodule

// File: rtl/sfr_rx.sv
module sfr_rx
  import sfr_pkg::*;
#(
  parameter int unsigned DIV_W       = 16,
  parameter int unsigned OSR         = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DIV_W-1:0]  div,
  input  sfr_fmt_t          fmt,
  input  logic              en,
  input  logic              line,
  output logic              push,
  output logic [SFR_DW-1:0] push_data,
  output logic              push_par_err,
  output logic              push_frm_err
);

  localparam int unsigned SUB_W = $clog2(OSR);
  localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(OSR - 1);
  localparam logic [SUB_W-1:0] SUB_MID  = SUB_W'(OSR / 2 - 1);

  typedef enum logic [2:0] {R_IDLE, R_START, R_DATA, R_PAR, R_STOP} rx_st_t;

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   cur;
  logic                   prev_q;
  rx_st_t                 st_q;
  logic [SUB_W-1:0]       sub_q;
  logic [2:0]             bitn_q;
  logic [SFR_DW-1:0]      sh_q;
  logic                   par_bit_q;
  sfr_fmt_t               fmt_q;
  logic                   tick;
  logic                   start_det;
  logic                   sample;
  logic [2:0]             last_data;

  for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q[0] <= 1'b1;
        else        sync_q[0] <= line;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q[i] <= 1'b1;
        else        sync_q[i] <= sync_q[i-1];
      end
    end
  end

  assign cur       = sync_q[SYNC_STAGES-1];
  assign start_det = en && (st_q == R_IDLE) && prev_q && !cur;
  assign sample    = tick && (sub_q == SUB_MID);
  assign last_data = fmt_q.len8 ? 3'd7 : 3'd6;

  sfr_tick_gen #(.DIV_W(DIV_W)) u_tick (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (start_det),
    .div  (div),
    .tick (tick)
  );

  assign push         = en && sample && (st_q == R_STOP);
  assign push_data    = fmt_q.len8 ? sh_q : {1'b0, sh_q[SFR_DW-1:1]};
  assign push_par_err = fmt_q.par_en &&
                        (sfr_parity(push_data, fmt_q.len8, fmt_q.par_odd) != par_bit_q);
  assign push_frm_err = !cur;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q    <= 1'b1;
      st_q      <= R_IDLE;
      sub_q     <= '0;
      bitn_q    <= '0;
      sh_q      <= '0;
      par_bit_q <= 1'b0;
      fmt_q     <= '0;
    end else begin
      prev_q <= cur;
      if (!en) begin
        st_q <= R_IDLE;
      end else if (start_det) begin
        st_q   <= R_START;
        sub_q  <= '0;
        bitn_q <= '0;
        fmt_q  <= fmt;
      end else if ((st_q != R_IDLE) && tick) begin
        sub_q <= (sub_q == SUB_LAST) ? '0 : sub_q + 1'b1;
        if (sub_q == SUB_MID) begin
          case (st_q)
            R_START: st_q <= cur ? R_IDLE : R_DATA;
            R_DATA: begin
              sh_q <= {cur, sh_q[SFR_DW-1:1]};
              if (bitn_q == last_data) begin
                st_q <= fmt_q.par_en ? R_PAR : R_STOP;
              end else begin
                bitn_q <= bitn_q + 1'b1;
              end
            end
            R_PAR: begin
              par_bit_q <= cur;
              st_q      <= R_STOP;
            end
            R_STOP:  st_q <= R_IDLE;
            default: st_q <= R_IDLE;
          endcase
        end
      end
    end
  end

endmodule

// File: rtl/sfr_rx_out.sv
module sfr_rx_out
  import sfr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [SFR_DW-1:0] push_data,
  input  logic              push_par_err,
  input  logic              push_frm_err,
  input  logic              ready,
  output logic              valid,
  output logic [SFR_DW-1:0] data,
  output logic              par_err,
  output logic              frm_err,
  output logic              ovr_err,
  output logic [1:0]        err_code
);

  logic     lost_q;
  logic     free;
  sfr_err_t code_d;

  assign free = !valid || ready;

  always_comb begin
    if (push_par_err)      code_d = ERR_PARITY;
    else if (push_frm_err) code_d = ERR_FRAME;
    else if (lost_q)       code_d = ERR_OVERRUN;
    else                   code_d = ERR_NONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid    <= 1'b0;
      data     <= '0;
      par_err  <= 1'b0;
      frm_err  <= 1'b0;
      ovr_err  <= 1'b0;
      err_code <= ERR_NONE;
      lost_q   <= 1'b0;
    end else if (push && free) begin
      valid    <= 1'b1;
      data     <= push_data;
      par_err  <= push_par_err;
      frm_err  <= push_frm_err;
      ovr_err  <= lost_q;
      err_code <= code_d;
      lost_q   <= 1'b0;
    end else begin
      if (valid && ready) valid <= 1'b0;
      if (push) lost_q <= 1'b1;
    end
  end

endmodule

// File: rtl/serial_framer.sv
module serial_framer
  import sfr_pkg::*;
#(
  parameter int unsigned DIV_W       = 16,
  parameter int unsigned OSR         = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] divisor,
  input  logic             cfg_len8,
  input  logic             cfg_two_stop,
  input  logic             cfg_par_en,
  input  logic             cfg_par_odd,
  input  logic             tx_en,
  input  logic [7:0]       tx_data,
  input  logic             tx_valid,
  output logic             tx_ready,
  output logic             txd,
  output logic             tx_idle,
  input  logic             rx_en,
  input  logic             rxd,
  output logic [7:0]       rx_data,
  output logic             rx_par_err,
  output logic             rx_frm_err,
  output logic             rx_ovr_err,
  output logic [1:0]       rx_err_code,
  output logic             rx_valid,
  input  logic             rx_ready
);

  sfr_fmt_t          fmt;
  logic              push;
  logic [SFR_DW-1:0] push_data;
  logic              push_par_err;
  logic              push_frm_err;

  assign fmt = '{len8: cfg_len8, two_stop: cfg_two_stop,
                 par_en: cfg_par_en, par_odd: cfg_par_odd};

  sfr_tx #(.DIV_W(DIV_W), .OSR(OSR)) u_tx (
    .clk  (clk),
    .rst_n(rst_n),
    .div  (divisor),
    .fmt  (fmt),
    .en   (tx_en),
    .data (tx_data),
    .valid(tx_valid),
    .ready(tx_ready),
    .line (txd),
    .idle (tx_idle)
  );

  sfr_rx #(.DIV_W(DIV_W), .OSR(OSR), .SYNC_STAGES(SYNC_STAGES)) u_rx (
    .clk         (clk),
    .rst_n       (rst_n),
    .div         (divisor),
    .fmt         (fmt),
    .en          (rx_en),
    .line        (rxd),
    .push        (push),
    .push_data   (push_data),
    .push_par_err(push_par_err),
    .push_frm_err(push_frm_err)
  );

  sfr_rx_out u_out (
    .clk         (clk),
    .rst_n       (rst_n),
    .push        (push),
    .push_data   (push_data),
    .push_par_err(push_par_err),
    .push_frm_err(push_frm_err),
    .ready       (rx_ready),
    .valid       (rx_valid),
    .data        (rx_data),
    .par_err     (rx_par_err),
    .frm_err     (rx_frm_err),
    .ovr_err     (rx_ovr_err),
    .err_code    (rx_err_code)
  );

endmodule

// File: rtl/sfr_checker.sv
module sfr_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       tx_en,
  input logic       tx_valid,
  input logic       tx_ready,
  input logic       txd,
  input logic       tx_idle,
  input logic       rx_en,
  input logic       rx_valid,
  input logic       rx_ready,
  input logic [7:0] rx_data,
  input logic       rx_par_err,
  input logic       rx_frm_err,
  input logic       rx_ovr_err,
  input logic [1:0] rx_err_code
);

  p_start_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && tx_ready |=> !txd && !tx_ready);

  p_idle_line_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
    tx_idle |-> txd);

  p_rx_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && !rx_ready |=> rx_valid && $stable(rx_data) && $stable(rx_err_code)
                              && $stable(rx_ovr_err) && $stable(rx_par_err)
                              && $stable(rx_frm_err));

  p_parity_rank_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && rx_par_err |-> rx_err_code == 2'd1);

  p_frame_rank_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && !rx_par_err && rx_frm_err |-> rx_err_code == 2'd2);

  p_tx_gate_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |-> !tx_ready);

  p_rx_gate_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en && !rx_valid |=> !rx_valid);

endmodule

bind serial_framer sfr_checker u_sfr_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .tx_en      (tx_en),
  .tx_valid   (tx_valid),
  .tx_ready   (tx_ready),
  .txd        (txd),
  .tx_idle    (tx_idle),
  .rx_en      (rx_en),
  .rx_valid   (rx_valid),
  .rx_ready   (rx_ready),
  .rx_data    (rx_data),
  .rx_par_err (rx_par_err),
  .rx_frm_err (rx_frm_err),
  .rx_ovr_err (rx_ovr_err),
  .rx_err_code(rx_err_code)
);

// File: tb/tb_serial_framer.sv
module tb_serial_framer;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] c_div = 16'd1;
  logic        c_len8 = 1'b1;
  logic        c_stop2 = 1'b0;
  logic        c_pen = 1'b0;
  logic        c_odd = 1'b0;
  logic        tx_en = 1'b1;
  logic [7:0]  tx_data = 8'h00;
  logic        tx_valid = 1'b0;
  logic        tx_ready;
  logic        txd;
  logic        tx_idle;
  logic        rx_en = 1'b1;
  logic        rxd = 1'b1;
  logic [7:0]  rx_data;
  logic        rx_par_err;
  logic        rx_frm_err;
  logic        rx_ovr_err;
  logic [1:0]  rx_err_code;
  logic        rx_valid;
  logic        rx_ready = 1'b0;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  serial_framer dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .divisor     (c_div),
    .cfg_len8    (c_len8),
    .cfg_two_stop(c_stop2),
    .cfg_par_en  (c_pen),
    .cfg_par_odd (c_odd),
    .tx_en       (tx_en),
    .tx_data     (tx_data),
    .tx_valid    (tx_valid),
    .tx_ready    (tx_ready),
    .txd         (txd),
    .tx_idle     (tx_idle),
    .rx_en       (rx_en),
    .rxd         (rxd),
    .rx_data     (rx_data),
    .rx_par_err  (rx_par_err),
    .rx_frm_err  (rx_frm_err),
    .rx_ovr_err  (rx_ovr_err),
    .rx_err_code (rx_err_code),
    .rx_valid    (rx_valid),
    .rx_ready    (rx_ready)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp,
                     input string what);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic exp_par(input logic [7:0] d, input logic l8, input logic od);
    logic [7:0] m;
    m = l8 ? d : (d & 8'h7F);
    return (^m) ^ od;
  endfunction

  function automatic logic exp_bit(input int i, input logic [7:0] d, input logic l8,
                                   input logic pe, input logic od);
    int nd;
    nd = l8 ? 8 : 7;
    if (i == 0) return 1'b0;
    if (i <= nd) return d[i-1];
    if (pe && (i == nd + 1)) return exp_par(d, l8, od);
    return 1'b1;
  endfunction

  // Send one byte and check every bit of the frame on txd, at both ends of each bit.
  task automatic tx_frame(input logic [7:0] d, input bit flip);
    logic l8, s2, pe, od, e;
    int bb, nd, n;
    string tg;
    l8 = c_len8; s2 = c_stop2; pe = c_pen; od = c_odd;
    bb = 16 * (int'(c_div) + 1);
    nd = l8 ? 8 : 7;
    n  = 1 + nd + (pe ? 1 : 0) + (s2 ? 2 : 1);
    tx_data  = d;
    tx_valid = 1'b1;
    while (!tx_ready) @(negedge clk);
    @(negedge clk);
    tx_valid = 1'b0;
    chk("R5", tx_ready, 0, "ready low during frame");
    if (flip) begin
      c_len8 = !l8; c_pen = !pe; c_stop2 = !s2; c_odd = !od;
    end
    for (int i = 0; i < n; i++) begin
      e = exp_bit(i, d, l8, pe, od);
      if (flip) tg = "R5";
      else if (i <= nd) tg = "R2";
      else if (pe && (i == nd + 1)) tg = "R3";
      else tg = "R4";
      chk(tg, txd, e, $sformatf("bit %0d start of 0x%02h", i, d));
      repeat (bb - 1) @(negedge clk);
      chk("R1", txd, e, $sformatf("bit %0d end of 0x%02h", i, d));
      if (i == n - 1) chk("R6", tx_idle, 0, "idle before last stop ends");
      @(negedge clk);
    end
    chk("R6", tx_idle, 1, "idle after last stop");
    chk("R6", txd, 1, "line high when idle");
    if (flip) begin
      c_len8 = l8; c_pen = pe; c_stop2 = s2; c_odd = od;
    end
  endtask

  // Drive one character onto rxd; the caller is at a falling clock edge.
  task automatic rx_frame(input logic [7:0] d, input bit bad_par, input bit bad_stop);
    int bb, nd;
    bb = 16 * (int'(c_div) + 1);
    nd = c_len8 ? 8 : 7;
    rxd = 1'b0;
    repeat (bb) @(negedge clk);
    for (int i = 0; i < nd; i++) begin
      rxd = d[i];
      repeat (bb) @(negedge clk);
    end
    if (c_pen) begin
      rxd = exp_par(d, c_len8, c_odd) ^ bad_par;
      repeat (bb) @(negedge clk);
    end
    rxd = !bad_stop;
    repeat (bb) @(negedge clk);
    if (c_stop2) begin
      rxd = 1'b1;
      repeat (bb) @(negedge clk);
    end
    rxd = 1'b1;
    repeat (bb) @(negedge clk);
  endtask

  task automatic rx_take(input logic [7:0] d, input logic pe_f, input logic fe_f,
                         input logic ov_f, input logic [1:0] code, input string req);
    chk(req, rx_valid, 1, "character offered");
    chk(req, rx_data, c_len8 ? d : (d & 8'h7F), "data");
    chk(req, rx_par_err, pe_f, "parity flag");
    chk(req, rx_frm_err, fe_f, "frame flag");
    chk(req, rx_ovr_err, ov_f, "overrun flag");
    chk(req, rx_err_code, code, "error code");
    rx_ready = 1'b1;
    @(negedge clk);
    rx_ready = 1'b0;
    chk(req, rx_valid, 0, "released after take");
  endtask

  // Clocks from the falling start edge to the negedge before the first-stop sample edge.
  function automatic int stop_lead();
    int s;
    s = 1 + (c_len8 ? 8 : 7) + (c_pen ? 1 : 0);
    return 2 + (8 + 16 * s) * (int'(c_div) + 1);
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: run did not complete");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    logic l8, pe, bp, bs;
    void'($urandom(32'h5EED_1234));
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // Reset state
    chk("R6", txd, 1, "reset line high");
    chk("R6", tx_idle, 1, "reset idle");
    chk("R5", tx_ready, 1, "reset ready");
    chk("R10", rx_valid, 0, "reset no character");

    // Directed transmit formats
    c_div = 16'd1; c_len8 = 1; c_stop2 = 0; c_pen = 0; c_odd = 0;
    tx_frame(8'hA5, 1'b0);
    c_len8 = 0; c_pen = 1; c_odd = 0;
    tx_frame(8'hC3, 1'b0);
    c_len8 = 1; c_pen = 1; c_odd = 1; c_stop2 = 1;
    tx_frame(8'h00, 1'b0);
    c_div = 16'd0; c_pen = 1; c_odd = 0; c_stop2 = 0;
    tx_frame(8'hFF, 1'b0);
    c_div = 16'd2;
    tx_frame(8'h5A, 1'b1);

    // Transmit gated off: byte offered but never taken
    tx_en = 1'b0;
    tx_data = 8'h3C;
    tx_valid = 1'b1;
    repeat (60) @(negedge clk);
    chk("R12", tx_ready, 0, "ready low while disabled");
    chk("R12", txd, 1, "line untouched while disabled");
    chk("R6", tx_idle, 0, "not idle with byte pending");
    tx_en = 1'b1;
    tx_frame(8'h3C, 1'b0);

    // Random transmit
    for (int k = 0; k < 12; k++) begin
      c_div = 16'($urandom_range(0, 2));
      c_len8 = 1'($urandom); c_stop2 = 1'($urandom);
      c_pen = 1'($urandom); c_odd = 1'($urandom);
      tx_frame(8'($urandom), 1'b0);
    end

    // Directed receive
    c_div = 16'd1; c_len8 = 1; c_stop2 = 0; c_pen = 1; c_odd = 0;
    rx_frame(8'h96, 0, 0);
    rx_take(8'h96, 0, 0, 0, 2'd0, "R7");
    rx_frame(8'h96, 1, 0);
    rx_take(8'h96, 1, 0, 0, 2'd1, "R8");
    rx_frame(8'h21, 0, 1);
    rx_take(8'h21, 0, 1, 0, 2'd2, "R9");
    rx_frame(8'h21, 1, 1);
    rx_take(8'h21, 1, 1, 0, 2'd1, "R11");
    c_len8 = 0; c_pen = 0;
    rx_frame(8'hF0, 0, 0);
    rx_take(8'hF0, 0, 0, 0, 2'd0, "R7");

    // Short low pulse must not make a character
    rxd = 1'b0;
    repeat (3 * (int'(c_div) + 1)) @(negedge clk);
    rxd = 1'b1;
    repeat (64) @(negedge clk);
    chk("R7", rx_valid, 0, "glitch dropped");

    // Receive gated off
    rx_en = 1'b0;
    rx_frame(8'h55, 0, 0);
    chk("R12", rx_valid, 0, "no character while disabled");
    rx_en = 1'b1;
    repeat (4) @(negedge clk);

    // Completion and take in the same edge: nothing lost
    c_len8 = 1; c_pen = 1; c_odd = 1; c_stop2 = 0;
    rx_frame(8'h11, 0, 0);
    chk("R10", rx_valid, 1, "first held");
    fork
      rx_frame(8'h22, 0, 0);
      begin
        repeat (stop_lead()) @(negedge clk);
        rx_ready = 1'b1;
        @(negedge clk);
        rx_ready = 1'b0;
      end
    join
    rx_take(8'h22, 0, 0, 0, 2'd0, "R10");

    // Take one edge late: second character lost, next one marked
    rx_frame(8'h33, 0, 0);
    fork
      rx_frame(8'h44, 0, 0);
      begin
        repeat (stop_lead() + 1) @(negedge clk);
        rx_ready = 1'b1;
        @(negedge clk);
        rx_ready = 1'b0;
      end
    join
    chk("R10", rx_valid, 0, "late take left output empty");
    rx_frame(8'h55, 0, 0);
    rx_take(8'h55, 0, 0, 1, 2'd3, "R10");

    // Held character stays; overrun ranks below frame error
    rx_frame(8'h66, 0, 0);
    rx_frame(8'h77, 0, 0);
    rx_take(8'h66, 0, 0, 0, 2'd0, "R10");
    rx_frame(8'h88, 0, 1);
    rx_take(8'h88, 0, 1, 1, 2'd2, "R11");

    // Random receive
    for (int k = 0; k < 14; k++) begin
      c_div = 16'($urandom_range(0, 2));
      c_len8 = 1'($urandom); c_stop2 = 1'($urandom);
      c_pen = 1'($urandom); c_odd = 1'($urandom);
      d = 8'($urandom);
      l8 = c_len8; pe = c_pen;
      bp = pe && ($urandom_range(0, 3) == 0);
      bs = ($urandom_range(0, 5) == 0);
      rx_frame(d, bp, bs);
      rx_take(d, bp, bs, 0, bp ? 2'd1 : (bs ? 2'd2 : 2'd0), "R8");
    end

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule